// File: doc/BRIEF.md
# Affinity Routing Target Matcher

This block takes an interrupt's programmed target affinity and decides which one of a set of connected processors it selects. An affinity is a 32-bit hierarchical address made of four 8-bit level fields. Each processor presents its own affinity value, a participation flag and a flag marking it as a three-level-only processor. It also presents a global setting that chooses whether the top level is significant. The block compares the target against every processor in parallel and returns a one-hot target vector. If no processor matches, it raises a no-target flag.

Routing is gated per security domain. A Secure request is routed only when the Secure routing enable is set. A Non-secure request is routed only when the Non-secure routing enable is set. When the relevant enable is clear, the block returns an empty vector and raises a disabled flag. A request is presented for one cycle with a valid strobe. The result appears on the registered outputs after the next rising clock edge.

Top module: `aff_route_match`

## Requirements
- R1: A request sampled with `req_valid_i` high produces `tgt_vld_o` high after the next rising edge, with all result fields for that request. Without a request, `tgt_vld_o`, `tgt_vec_o`, `no_tgt_o` and `disabled_o` are all zero. During reset, all outputs are zero.
- R2: Level 0 is bits [7:0] of an affinity, level 1 is bits [15:8], level 2 is bits [23:16] and level 3 is bits [31:24]. Processor i's affinity occupies bits [32*i+31:32*i] of `pe_aff_i`. Levels 0 to 2 must always be equal for a match.
- R3: With `cfg_four_lvl_i` = 1, a processor whose `pe_narrow_i` bit is 0 matches only when all four level fields are equal.
- R4: With `cfg_four_lvl_i` = 0, level 3 takes no part in the comparison for any processor.
- R5: A processor whose `pe_narrow_i` bit is 1 is compared on levels 0 to 2 only, even when `cfg_four_lvl_i` = 1.
- R6: A request with `req_secure_i` = 1 is routed only when `cfg_route_en_s_i` = 1. Otherwise the result has `tgt_vec_o` = 0, `disabled_o` = 1 and `no_tgt_o` = 0.
- R7: A request with `req_secure_i` = 0 is routed only when `cfg_route_en_ns_i` = 1. Otherwise it is reported as disabled in the same way as R6.
- R8: A processor whose `pe_part_i` bit is 0 is never set in `tgt_vec_o`.
- R9: `tgt_vec_o` is one-hot or zero. When several participating processors match, the lowest-indexed one is selected.
- R10: An enabled request with no matching participating processor gives `tgt_vec_o` = 0, `no_tgt_o` = 1 and `disabled_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_aff_i | input | 32 | Target affinity of the request |
| req_secure_i | input | 1 | 1 = Secure request, 0 = Non-secure |
| cfg_four_lvl_i | input | 1 | 1 = level 3 significant |
| cfg_route_en_s_i | input | 1 | Secure routing enable |
| cfg_route_en_ns_i | input | 1 | Non-secure routing enable |
| pe_aff_i | input | NUM_PE*32 | Packed processor affinities |
| pe_part_i | input | NUM_PE | Processor participation flags |
| pe_narrow_i | input | NUM_PE | Processor supports three levels only |
| tgt_vld_o | output | 1 | Result valid |
| tgt_vec_o | output | NUM_PE | One-hot selected processor |
| no_tgt_o | output | 1 | Enabled request matched nothing |
| disabled_o | output | 1 | Routing disabled for the request's domain |

## Verification
Two functions can fall in the same cycle. Duplicate-match resolution and the participation mask can both act on one request, and the level-3 mask can differ from one processor to the next. The bench provokes this by drawing every level field from a two-value set, so several processors often share an affinity. Random participation and narrow flags then knock out or widen individual candidates. Each result is judged against a bench function that first applies the domain gate, then walks the processors upward and returns the first participating match.

// File: rtl/aff_route_pkg.sv
package aff_route_pkg;
  localparam int unsigned DEF_LVL_W   = 8;
  localparam int unsigned DEF_NUM_LVL = 4;
  localparam int unsigned DEF_NUM_PE  = 8;

  typedef struct packed {
    logic vld;
    logic no_tgt;
    logic disabled;
  } rsp_flags_t;

  localparam rsp_flags_t RSP_IDLE = '{vld: 1'b0, no_tgt: 1'b0, disabled: 1'b0};
endpackage

// File: rtl/aff_lvl_cmp.sv
module aff_lvl_cmp #(
  parameter int unsigned LVL_W   = 8,
  parameter int unsigned NUM_LVL = 4,
  localparam int unsigned AFF_W  = LVL_W * NUM_LVL
) (
  input  logic [AFF_W-1:0] tgt_aff_i,
  input  logic [AFF_W-1:0] pe_aff_i,
  input  logic             use_top_i,
  output logic             match_o
);
  logic [NUM_LVL-1:0] lvl_eq;
  logic [NUM_LVL-1:0] lvl_sig;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    assign lvl_eq[l] = (tgt_aff_i[l*LVL_W +: LVL_W] == pe_aff_i[l*LVL_W +: LVL_W]);
    if (l == NUM_LVL - 1) begin : g_top
      assign lvl_sig[l] = use_top_i;
    end else begin : g_low
      assign lvl_sig[l] = 1'b1;
    end
  end

  // a level passes if equal or not significant
  assign match_o = &(lvl_eq | ~lvl_sig);
endmodule

// File: rtl/aff_pick_first.sv
module aff_pick_first #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  assign gnt_o = req_i & (~req_i + N'(1));
  assign any_o = |req_i;
endmodule

// File: rtl/aff_route_gate.sv
module aff_route_gate (
  input  logic valid_i,
  input  logic secure_i,
  input  logic en_s_i,
  input  logic en_ns_i,
  output logic route_ok_o,
  output logic blocked_o
);
  logic dom_en;
  assign dom_en     = secure_i ? en_s_i : en_ns_i;
  assign route_ok_o = valid_i & dom_en;
  assign blocked_o  = valid_i & ~dom_en;
endmodule

// File: rtl/aff_route_match.sv
module aff_route_match
  import aff_route_pkg::*;
#(
  parameter int unsigned NUM_PE  = DEF_NUM_PE,
  parameter int unsigned LVL_W   = DEF_LVL_W,
  parameter int unsigned NUM_LVL = DEF_NUM_LVL,
  localparam int unsigned AFF_W  = LVL_W * NUM_LVL
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [AFF_W-1:0]        req_aff_i,
  input  logic                    req_secure_i,
  input  logic                    cfg_four_lvl_i,
  input  logic                    cfg_route_en_s_i,
  input  logic                    cfg_route_en_ns_i,
  input  logic [NUM_PE*AFF_W-1:0] pe_aff_i,
  input  logic [NUM_PE-1:0]       pe_part_i,
  input  logic [NUM_PE-1:0]       pe_narrow_i,
  output logic                    tgt_vld_o,
  output logic [NUM_PE-1:0]       tgt_vec_o,
  output logic                    no_tgt_o,
  output logic                    disabled_o
);
  logic [NUM_PE-1:0] pe_hit;
  logic [NUM_PE-1:0] pe_cand;
  logic [NUM_PE-1:0] pe_sel;
  logic              any_cand;
  logic              route_ok;
  logic              blocked;

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    logic use_top;
    assign use_top = cfg_four_lvl_i & ~pe_narrow_i[i];
    aff_lvl_cmp #(
      .LVL_W  (LVL_W),
      .NUM_LVL(NUM_LVL)
    ) u_cmp (
      .tgt_aff_i(req_aff_i),
      .pe_aff_i (pe_aff_i[i*AFF_W +: AFF_W]),
      .use_top_i(use_top),
      .match_o  (pe_hit[i])
    );
  end

  assign pe_cand = pe_hit & pe_part_i;

  aff_pick_first #(.N(NUM_PE)) u_pick (
    .req_i(pe_cand),
    .gnt_o(pe_sel),
    .any_o(any_cand)
  );

  aff_route_gate u_gate (
    .valid_i   (req_valid_i),
    .secure_i  (req_secure_i),
    .en_s_i    (cfg_route_en_s_i),
    .en_ns_i   (cfg_route_en_ns_i),
    .route_ok_o(route_ok),
    .blocked_o (blocked)
  );

  rsp_flags_t        flags_d, flags_q;
  logic [NUM_PE-1:0] vec_d, vec_q;

  always_comb begin
    flags_d          = RSP_IDLE;
    vec_d            = '0;
    flags_d.vld      = req_valid_i;
    flags_d.disabled = blocked;
    if (route_ok) begin
      vec_d          = pe_sel;
      flags_d.no_tgt = ~any_cand;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= RSP_IDLE;
      vec_q   <= '0;
    end else begin
      flags_q <= flags_d;
      vec_q   <= vec_d;
    end
  end

  assign tgt_vld_o  = flags_q.vld;
  assign tgt_vec_o  = vec_q;
  assign no_tgt_o   = flags_q.no_tgt;
  assign disabled_o = flags_q.disabled;
endmodule

// File: rtl/aff_route_match_chk.sv
module aff_route_match_chk #(
  parameter int unsigned NUM_PE = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_secure_i,
  input logic              cfg_route_en_s_i,
  input logic              cfg_route_en_ns_i,
  input logic [NUM_PE-1:0] pe_part_i,
  input logic              tgt_vld_o,
  input logic [NUM_PE-1:0] tgt_vec_o,
  input logic              no_tgt_o,
  input logic              disabled_o
);
  a_r1_vld_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_vld_o |-> $past(req_valid_i));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_vld_o |-> (tgt_vec_o == '0 && !no_tgt_o && !disabled_o));

  a_r6_secure_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_vld_o && $past(req_secure_i) && !$past(cfg_route_en_s_i))
      |-> (disabled_o && tgt_vec_o == '0 && !no_tgt_o));

  a_r7_nonsecure_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_vld_o && !$past(req_secure_i) && !$past(cfg_route_en_ns_i))
      |-> (disabled_o && tgt_vec_o == '0 && !no_tgt_o));

  a_r8_only_participants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_vld_o |-> ((tgt_vec_o & ~$past(pe_part_i)) == '0));

  a_r9_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tgt_vec_o));

  a_r10_no_tgt_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_tgt_o |-> (tgt_vec_o == '0 && !disabled_o));
endmodule

bind aff_route_match aff_route_match_chk #(.NUM_PE(NUM_PE)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_valid_i      (req_valid_i),
  .req_secure_i     (req_secure_i),
  .cfg_route_en_s_i (cfg_route_en_s_i),
  .cfg_route_en_ns_i(cfg_route_en_ns_i),
  .pe_part_i        (pe_part_i),
  .tgt_vld_o        (tgt_vld_o),
  .tgt_vec_o        (tgt_vec_o),
  .no_tgt_o         (no_tgt_o),
  .disabled_o       (disabled_o)
);

// File: tb/sim_aff_route_match.sv
`timescale 1ns/1ps
module sim_aff_route_match;
  localparam int NPE = 8;
  localparam int AW  = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid_i = 1'b0;
  logic [AW-1:0]   req_aff_i = '0;
  logic            req_secure_i = 1'b0;
  logic            cfg_four_lvl_i = 1'b1;
  logic            cfg_route_en_s_i = 1'b1;
  logic            cfg_route_en_ns_i = 1'b1;
  logic [NPE*AW-1:0] pe_aff_i = '0;
  logic [NPE-1:0]  pe_part_i = '1;
  logic [NPE-1:0]  pe_narrow_i = '0;
  logic            tgt_vld_o;
  logic [NPE-1:0]  tgt_vec_o;
  logic            no_tgt_o;
  logic            disabled_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  aff_route_match #(.NUM_PE(NPE)) u0 (.*);

  function automatic logic en_now();
    return req_secure_i ? cfg_route_en_s_i : cfg_route_en_ns_i;
  endfunction

  function automatic logic [NPE-1:0] exp_vec();
    if (!en_now()) return '0;
    for (int i = 0; i < NPE; i++) begin
      logic [AW-1:0] a;
      logic top;
      a   = pe_aff_i[i*AW +: AW];
      top = cfg_four_lvl_i && !pe_narrow_i[i];
      if (pe_part_i[i] && a[23:0] == req_aff_i[23:0] &&
          (!top || a[31:24] == req_aff_i[31:24]))
        return NPE'(1) << i;
    end
    return '0;
  endfunction

  task automatic chk(string tag, logic [NPE+2:0] act, logic [NPE+2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got vld/vec/no/dis=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic txn(string tag);
    logic [NPE-1:0] ev;
    logic ee;
    ev = exp_vec();
    ee = en_now();
    req_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(tag, {tgt_vld_o, tgt_vec_o, no_tgt_o, disabled_o},
        {1'b1, ev, ee && ev == '0, !ee});
  endtask

  function automatic logic [AW-1:0] rnd_aff();
    logic [AW-1:0] a;
    for (int l = 0; l < 4; l++) a[l*8 +: 8] = 8'($urandom % 2);
    return a;
  endfunction

  task automatic set_pe(int i, logic [AW-1:0] a);
    pe_aff_i[i*AW +: AW] = a;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    for (int i = 0; i < NPE; i++) set_pe(i, {8'(i), 8'h10, 8'h20, 8'h30});
    repeat (3) @(negedge clk_i);
    chk("R1 reset", {tgt_vld_o, tgt_vec_o, no_tgt_o, disabled_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1 idle", {tgt_vld_o, tgt_vec_o, no_tgt_o, disabled_o}, '0);

    // R2/R3: exact four-level hit on PE5
    req_aff_i = {8'd5, 8'h10, 8'h20, 8'h30};
    txn("R3 four level hit");
    chk("R3 vec", {3'b0, tgt_vec_o}, {3'b0, NPE'(1) << 5});
    // R2: level 0 differs
    req_aff_i = {8'd5, 8'h10, 8'h20, 8'h31};
    txn("R2 level0 mismatch");
    // R3: top level absent from all PEs
    req_aff_i = {8'd9, 8'h10, 8'h20, 8'h30};
    txn("R3 top mismatch");
    // R4: three-level mode ignores top, lowest index wins (R9)
    cfg_four_lvl_i = 1'b0;
    txn("R4 three level");
    chk("R9 lowest", {3'b0, tgt_vec_o}, {3'b0, NPE'(1)});
    // R8: remove PEs 0..2
    pe_part_i = 8'b1111_1000;
    txn("R8 part mask");
    // R5: narrow PE ignores top in four-level mode
    cfg_four_lvl_i = 1'b1;
    pe_part_i = '1;
    pe_narrow_i = 8'b0100_0000;
    txn("R5 narrow pe");
    chk("R5 vec", {3'b0, tgt_vec_o}, {3'b0, NPE'(1) << 6});
    pe_narrow_i = '0;
    // R6/R7 gates
    req_aff_i = {8'd2, 8'h10, 8'h20, 8'h30};
    req_secure_i = 1'b1; cfg_route_en_s_i = 1'b0;
    txn("R6 secure off");
    req_secure_i = 1'b0;
    txn("R7 ns on while s off");
    cfg_route_en_s_i = 1'b1; cfg_route_en_ns_i = 1'b0;
    txn("R7 ns off");
    req_secure_i = 1'b1;
    txn("R6 secure on");
    cfg_route_en_ns_i = 1'b1;
    // R10: nothing participates
    pe_part_i = '0;
    txn("R10 none");
    pe_part_i = '1;
    // R9: duplicates at 3 and 6
    set_pe(3, 32'hAABB_CCDD); set_pe(6, 32'hAABB_CCDD);
    req_aff_i = 32'hAABB_CCDD;
    txn("R9 dup");

    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < NPE; i++) set_pe(i, rnd_aff());
      req_aff_i         = rnd_aff();
      req_secure_i      = 1'($urandom);
      cfg_four_lvl_i    = 1'($urandom);
      cfg_route_en_s_i  = ($urandom % 8) != 0;
      cfg_route_en_ns_i = ($urandom % 8) != 0;
      pe_part_i         = NPE'($urandom) | NPE'($urandom);
      pe_narrow_i       = NPE'($urandom) & NPE'($urandom);
      txn("R3 R4 R5 R8 R9 R10 random");
      if ((n % 7) == 0) begin
        @(negedge clk_i);
        chk("R1 gap", {tgt_vld_o, tgt_vec_o, no_tgt_o, disabled_o}, '0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule